// File: doc/BRIEF.md
# Shared ROM and SRAM Word-Access Sequencer

This block turns single word requests from an internal master into strobe sequences for two external memories that share one address bus and one data bus. One is a read-only device that is always 16 bits wide. The other is a static RAM whose width is set by a board strap: 16 bits or 8 bits. Each accepted request occupies a fixed slot of five internal clock ticks, whatever the target, the width or the direction. The pins therefore see the same cadence for every access, and the requester can plan its bandwidth in whole slots.

When the RAM is strapped narrow, each word is moved as two bytes inside the same slot. The low byte goes first with the byte-select line low, and the high byte follows with it high. A narrow read keeps the first byte in a holding register and returns the merged word with the done strobe. A narrow write produces two separate write-enable pulses, with a gap tick between them. Every pin leaves a registered output. The data bus is driven only while a write pulse is active, and it has idle ticks on both sides of every change of direction.

Top module: `extmem_slot_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is raised during a slot, both chip selects, output enable and write enable are high, byte select is low, the bus is not driven and done is low.
- R2: A request is accepted only while ready is high. Ready is high when idle and in the last tick of a slot. Each slot lasts 5 cycles, with done high for exactly one cycle in tick 4. A request held during ticks 0 to 3 of a running slot has no effect.
- R3: The selected chip select is low in ticks 0 to 3 of a slot and high in tick 4. The other chip select stays high, and both are never low together.
- R4: Output enable or write enable never falls in the same cycle as the chip select. Both stay high in tick 0.
- R5: A 16-bit read (ROM, or RAM strapped wide) holds output enable low in ticks 1 to 3. It returns the 16-bit bus value seen in tick 3 on the read data output, together with done.
- R6: ROM accesses are always 16-bit, whatever the strap. Byte select stays low during ROM slots.
- R7: A write request aimed at the ROM runs as a read: write enable stays high, the bus is not driven, and the ROM word is returned.
- R8: A narrow RAM read holds output enable low in ticks 1 to 3, with byte select low in tick 1 and high in ticks 2 to 3. It samples bus bits 7:0 in tick 1 as the low byte and in tick 3 as the high byte, and returns {high, low}.
- R9: A narrow RAM write pulses write enable low in tick 1, with byte select low and the low data byte on bus bits 7:0 (bits 15:8 zero). It pulses again in tick 3, with byte select high and the high byte. Write enable is high in tick 2.
- R10: A wide RAM write holds write enable low in ticks 1 to 3 and drives the whole word.
- R11: The bus drive enable is high only in cycles where write enable is low. It never rises in a cycle that directly follows one with output enable low.
- R12: The address output equals the request's 19-bit word address in all 5 ticks of its slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ram | input | 1 | 1 = RAM target, 0 = ROM target |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write word |
| ram_narrow | input | 1 | Strap: 1 = 8-bit RAM, 0 = 16-bit RAM |
| req_ready | output | 1 | Request accepted at this edge if valid |
| rd_data | output | 16 | Read word, valid with rd_done |
| rd_done | output | 1 | One-cycle end-of-slot strobe |
| mem_addr | output | 19 | External word address |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| ram_bsel | output | 1 | Byte select, lowest RAM address bit in narrow mode |
| mem_dq_o | output | 16 | Bus write data |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_i | input | 16 | Bus read data |

## Verification
Two things can fall in the same cycle: the done strobe of one slot and the acceptance of the next request, because ready is high in tick 4. The bench sets up this overlap by presenting each new request at the last tick of the previous slot. It does this for a write followed by a read, a read followed by a write, and a narrow access followed by a wide one. The check is that done and the previous read data appear in that tick, and that the new chip select, address and strobes start their tick-0 pattern in the very next cycle. The bus must still sit idle around every change of direction.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

  // Pin-side strobe set, all registered together.
  typedef struct packed {
    logic rom_cs_n;
    logic ram_cs_n;
    logic oe_n;
    logic we_n;
    logic bsel;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{
    rom_cs_n: 1'b1,
    ram_cs_n: 1'b1,
    oe_n:     1'b1,
    we_n:     1'b1,
    bsel:     1'b0,
    dq_oe:    1'b0
  };

  // Classification of an accepted request.
  typedef struct packed {
    logic is_ram;
    logic is_write;  // only ever set for RAM targets
    logic narrow;    // RAM strapped to 8 bits
  } kind_t;

endpackage

// File: rtl/extmem_slot_seq.sv
module extmem_slot_seq
  import extmem_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int SLOT_TICKS = 5,
  localparam int TICK_W    = $clog2(SLOT_TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ram,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ram_narrow,
  output logic              req_ready,
  output logic              busy_q,
  output logic [TICK_W-1:0] tick_q,
  output kind_t             kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              nxt_busy,
  output logic [TICK_W-1:0] nxt_tick,
  output kind_t             nxt_kind,
  output logic [DATA_W-1:0] nxt_wdata
);

  localparam logic [TICK_W-1:0] T_LAST = TICK_W'(SLOT_TICKS - 1);

  logic              accept;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] wdata_q;

  // New slot may start while the current one shows its last tick.
  assign req_ready = !busy_q || (tick_q == T_LAST);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt_busy  = busy_q;
    nxt_tick  = tick_q;
    nxt_kind  = kind_q;
    nxt_addr  = addr_q;
    nxt_wdata = wdata_q;
    if (accept) begin
      nxt_busy          = 1'b1;
      nxt_tick          = '0;
      nxt_kind.is_ram   = req_ram;
      nxt_kind.is_write = req_ram && req_write;
      nxt_kind.narrow   = req_ram && ram_narrow;
      nxt_addr          = req_addr;
      nxt_wdata         = req_wdata;
    end else if (busy_q) begin
      if (tick_q == T_LAST) nxt_busy = 1'b0;
      else                  nxt_tick = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      tick_q  <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      busy_q  <= nxt_busy;
      tick_q  <= nxt_tick;
      kind_q  <= nxt_kind;
      addr_q  <= nxt_addr;
      wdata_q <= nxt_wdata;
    end
  end

  // R2: inside a slot the tick counter advances by one every cycle.
  p_tick_step_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && tick_q != T_LAST) |=> (busy_q && tick_q == $past(tick_q) + 1'b1));

endmodule

// File: rtl/extmem_strobe_gen.sv
module extmem_strobe_gen
  import extmem_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SLOT_TICKS = 5,
  parameter int CS_SETUP   = 1,
  localparam int TICK_W    = $clog2(SLOT_TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_busy,
  input  logic [TICK_W-1:0] nxt_tick,
  input  kind_t             nxt_kind,
  input  logic [DATA_W-1:0] nxt_wdata,
  output strobe_t           strb_q,
  output logic [DATA_W-1:0] dq_o_q
);

  localparam int HALF = DATA_W / 2;
  // Tick plan: CS_SETUP ticks of select-only, a strobe window, one recovery tick.
  localparam logic [TICK_W-1:0] T_STB_BEG  = TICK_W'(CS_SETUP);
  localparam logic [TICK_W-1:0] T_STB_END  = TICK_W'(SLOT_TICKS - 2);
  localparam logic [TICK_W-1:0] T_LO_END   = TICK_W'(CS_SETUP);
  localparam logic [TICK_W-1:0] T_HI_BEG   = TICK_W'(CS_SETUP + 1);
  localparam logic [TICK_W-1:0] T_HI_PULSE = TICK_W'(CS_SETUP + 2);

  strobe_t           strb_d;
  logic [DATA_W-1:0] dq_d;
  logic [HALF-1:0]   lane_byte;
  logic              in_cs, in_stb, hi_half, pulse;

  always_comb begin
    in_cs   = nxt_busy && (nxt_tick <= T_STB_END);
    in_stb  = in_cs && (nxt_tick >= T_STB_BEG);
    hi_half = nxt_kind.narrow && (nxt_tick >= T_HI_BEG);
    if (nxt_kind.narrow)
      pulse = in_stb && nxt_kind.is_write &&
              ((nxt_tick <= T_LO_END) || (nxt_tick >= T_HI_PULSE));
    else
      pulse = in_stb && nxt_kind.is_write;
    lane_byte = hi_half ? nxt_wdata[DATA_W-1:HALF] : nxt_wdata[HALF-1:0];

    strb_d = STROBE_IDLE;
    if (in_cs) begin
      strb_d.rom_cs_n = nxt_kind.is_ram;
      strb_d.ram_cs_n = !nxt_kind.is_ram;
    end
    strb_d.oe_n  = !(in_stb && !nxt_kind.is_write);
    strb_d.we_n  = !pulse;
    strb_d.dq_oe = pulse;
    strb_d.bsel  = in_stb && hi_half;

    dq_d = dq_o_q;  // hold the pins when nothing is written
    if (pulse)
      dq_d = nxt_kind.narrow ? {{HALF{1'b0}}, lane_byte} : nxt_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= STROBE_IDLE;
      dq_o_q <= '0;
    end else begin
      strb_q <= strb_d;
      dq_o_q <= dq_d;
    end
  end

  p_cs_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!strb_q.rom_cs_n && !strb_q.ram_cs_n));

  p_oe_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(strb_q.oe_n) |-> $past(!strb_q.rom_cs_n || !strb_q.ram_cs_n));

  p_we_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(strb_q.we_n) |-> $past(!strb_q.ram_cs_n));

  p_turnaround_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(strb_q.dq_oe) |-> $past(strb_q.oe_n));

  p_no_fight_r11: assert property (@(posedge clk) disable iff (rst)
    !(strb_q.dq_oe && !strb_q.oe_n));

endmodule

// File: rtl/extmem_rd_merge.sv
module extmem_rd_merge
  import extmem_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SLOT_TICKS = 5,
  parameter int CS_SETUP   = 1,
  localparam int TICK_W    = $clog2(SLOT_TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_q,
  input  logic [TICK_W-1:0] tick_q,
  input  kind_t             kind_q,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] rd_data_q,
  output logic              done_q
);

  localparam int HALF = DATA_W / 2;
  localparam logic [TICK_W-1:0] T_LO_END  = TICK_W'(CS_SETUP);
  localparam logic [TICK_W-1:0] T_STB_END = TICK_W'(SLOT_TICKS - 2);

  logic [HALF-1:0] lo_q;
  logic            reading;

  assign reading = busy_q && !kind_q.is_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q      <= '0;
      rd_data_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= busy_q && (tick_q == T_STB_END);
      if (reading && kind_q.narrow && tick_q == T_LO_END)
        lo_q <= dq_i[HALF-1:0];
      if (reading && tick_q == T_STB_END)
        rd_data_q <= kind_q.narrow ? {dq_i[HALF-1:0], lo_q} : dq_i;
    end
  end

endmodule

// File: rtl/extmem_slot_ctrl.sv
module extmem_slot_ctrl
  import extmem_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 16,
  parameter int SLOT_TICKS = 5,
  parameter int CS_SETUP   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_ram,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ram_narrow,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              ram_bsel,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int TICK_W = $clog2(SLOT_TICKS);

  logic              busy_q, nxt_busy;
  logic [TICK_W-1:0] tick_q, nxt_tick;
  kind_t             kind_q, nxt_kind;
  logic [DATA_W-1:0] nxt_wdata;
  strobe_t           strb_q;

  extmem_slot_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_TICKS(SLOT_TICKS)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_ram(req_ram),
    .req_addr(req_addr), .req_wdata(req_wdata), .ram_narrow(ram_narrow),
    .req_ready(req_ready),
    .busy_q(busy_q), .tick_q(tick_q), .kind_q(kind_q), .addr_q(mem_addr),
    .nxt_busy(nxt_busy), .nxt_tick(nxt_tick), .nxt_kind(nxt_kind),
    .nxt_wdata(nxt_wdata)
  );

  extmem_strobe_gen #(
    .DATA_W(DATA_W), .SLOT_TICKS(SLOT_TICKS), .CS_SETUP(CS_SETUP)
  ) u_strb (
    .clk(clk), .rst(rst),
    .nxt_busy(nxt_busy), .nxt_tick(nxt_tick), .nxt_kind(nxt_kind),
    .nxt_wdata(nxt_wdata),
    .strb_q(strb_q), .dq_o_q(mem_dq_o)
  );

  extmem_rd_merge #(
    .DATA_W(DATA_W), .SLOT_TICKS(SLOT_TICKS), .CS_SETUP(CS_SETUP)
  ) u_rd (
    .clk(clk), .rst(rst),
    .busy_q(busy_q), .tick_q(tick_q), .kind_q(kind_q),
    .dq_i(mem_dq_i),
    .rd_data_q(rd_data), .done_q(rd_done)
  );

  assign rom_cs_n  = strb_q.rom_cs_n;
  assign ram_cs_n  = strb_q.ram_cs_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_we_n  = strb_q.we_n;
  assign ram_bsel  = strb_q.bsel;
  assign mem_dq_oe = strb_q.dq_oe;

  logic cs_any;
  assign cs_any = !rom_cs_n || !ram_cs_n;

  p_addr_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (cs_any && $past(cs_any)) |-> $stable(mem_addr));

  p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);

  p_rom_readonly_r7: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> (mem_we_n && !mem_dq_oe));

  p_rom_wide_r6: assert property (@(posedge clk) disable iff (rst)
    !rom_cs_n |-> !ram_bsel);

  p_drive_in_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_we_n && !ram_cs_n));

endmodule

// File: tb/extmem_slot_ctrl_test.sv
module extmem_slot_ctrl_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_ram = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        narrow = 1'b0;
  logic        req_ready, rd_done, rom_cs_n, ram_cs_n, mem_oe_n, mem_we_n;
  logic        ram_bsel, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_o, mem_dq_i;
  logic [18:0] mem_addr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  extmem_slot_ctrl uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_ram(req_ram),
    .req_addr(req_addr), .req_wdata(req_wdata), .ram_narrow(narrow),
    .req_ready(req_ready), .rd_data(rd_data), .rd_done(rd_done),
    .mem_addr(mem_addr), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .ram_bsel(ram_bsel),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model: 32 RAM bytes, ROM word is a function of the address.
  logic [7:0] bmem [0:31];

  function automatic logic [15:0] rom_word(input logic [18:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] ram_word(input logic [18:0] a);
    return {bmem[{a[3:0], 1'b1}], bmem[{a[3:0], 1'b0}]};
  endfunction

  always_comb begin
    mem_dq_i = 16'hDEAD;
    if (!mem_oe_n && !rom_cs_n) mem_dq_i = rom_word(mem_addr);
    else if (!mem_oe_n && !ram_cs_n)
      mem_dq_i = narrow ? {8'hEE, bmem[{mem_addr[3:0], ram_bsel}]}
                        : ram_word(mem_addr);
  end

  always @(posedge clk) begin
    if (!mem_we_n && !ram_cs_n) begin
      if (narrow) bmem[{mem_addr[3:0], ram_bsel}] <= mem_dq_o[7:0];
      else begin
        bmem[{mem_addr[3:0], 1'b0}] <= mem_dq_o[7:0];
        bmem[{mem_addr[3:0], 1'b1}] <= mem_dq_o[15:8];
      end
    end
  end

  task automatic chk(input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Presents one request at the current negedge and checks its 5 ticks.
  // junk=1 keeps valid high with a different request through tick 3.
  task automatic run_slot(input bit wr, input bit ram, input logic [18:0] a,
                          input logic [15:0] wd, input logic [15:0] exp_rd,
                          input bit junk);
    bit bm, ew, csel, stb, pulse;
    bm = ram && narrow;
    ew = wr && ram;
    req_valid = 1'b1; req_write = wr; req_ram = ram;
    req_addr = a; req_wdata = wd;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      if (t == 0) begin
        if (junk) begin req_ram = !ram; req_addr = ~a; req_write = !wr; end
        else req_valid = 1'b0;
      end
      if (t == 3) req_valid = 1'b0;
      csel  = (t <= 3);
      stb   = (t >= 1 && t <= 3);
      pulse = ew && (bm ? (t == 1 || t == 3) : stb);
      chk("R3", "rom_cs_n", rom_cs_n, !(csel && !ram));
      chk("R3", "ram_cs_n", ram_cs_n, !(csel && ram));
      chk("R4", "oe_n", mem_oe_n, !(stb && !ew));
      chk(ew ? (bm ? "R9" : "R10") : (ram ? "R4" : "R7"), "we_n", mem_we_n, !pulse);
      chk(ram ? "R8" : "R6", "bsel", ram_bsel, bm && (t == 2 || t == 3));
      chk("R11", "dq_oe", mem_dq_oe, pulse);
      if (pulse)
        chk(bm ? "R9" : "R10", "dq_o", mem_dq_o,
            bm ? (t == 1 ? {8'h00, wd[7:0]} : {8'h00, wd[15:8]}) : wd);
      chk("R12", "addr", mem_addr, a);
      chk("R2", "done", rd_done, t == 4);
      chk("R2", "ready", req_ready, t == 4);
      if (t == 4 && !ew)
        chk(ram ? (bm ? "R8" : "R5") : (narrow ? "R6" : "R5"), "rd_data", rd_data, exp_rd);
    end
  endtask

  task automatic check_idle(input string r);
    chk(r, "idle rom_cs_n", rom_cs_n, 1'b1);
    chk(r, "idle ram_cs_n", ram_cs_n, 1'b1);
    chk(r, "idle oe_n", mem_oe_n, 1'b1);
    chk(r, "idle we_n", mem_we_n, 1'b1);
    chk(r, "idle bsel", ram_bsel, 1'b0);
    chk(r, "idle dq_oe", mem_dq_oe, 1'b0);
    chk(r, "idle done", rd_done, 1'b0);
  endtask

  task automatic t_reset_state;  // R1
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    idle(2);
    chk("R2", "ready after reset", req_ready, 1'b1);
  endtask

  task automatic t_rom;  // R5, R6, R7
    narrow = 1'b0;
    run_slot(1'b0, 1'b0, 19'h12345, 16'h0, rom_word(19'h12345), 1'b0);
    narrow = 1'b1;
    run_slot(1'b0, 1'b0, 19'h7FFFF, 16'h0, rom_word(19'h7FFFF), 1'b0);
    run_slot(1'b1, 1'b0, 19'h00100, 16'hBEEF, rom_word(19'h00100), 1'b0);
    idle(2);
  endtask

  task automatic t_ram_wide;  // R5, R10
    narrow = 1'b0;
    run_slot(1'b0, 1'b1, 19'd3, 16'h0, ram_word(19'd3), 1'b0);
    run_slot(1'b1, 1'b1, 19'd5, 16'hC0DE, 16'h0, 1'b0);
    run_slot(1'b0, 1'b1, 19'd5, 16'h0, 16'hC0DE, 1'b0);
    idle(3);
  endtask

  task automatic t_ram_narrow;  // R8, R9
    narrow = 1'b1;
    run_slot(1'b0, 1'b1, 19'd2, 16'h0, ram_word(19'd2), 1'b0);
    run_slot(1'b1, 1'b1, 19'd9, 16'h1234, 16'h0, 1'b0);
    run_slot(1'b0, 1'b1, 19'd9, 16'h0, 16'h1234, 1'b0);
    narrow = 1'b0;  // wide view proves low byte landed at byte-select low
    run_slot(1'b0, 1'b1, 19'd9, 16'h0, 16'h1234, 1'b0);
    idle(2);
  endtask

  task automatic t_back_to_back;  // R2, R11: done and next accept coincide
    narrow = 1'b1;
    run_slot(1'b0, 1'b0, 19'h00042, 16'h0, rom_word(19'h00042), 1'b0);
    run_slot(1'b1, 1'b1, 19'd11, 16'hA55A, 16'h0, 1'b0);
    narrow = 1'b0;
    run_slot(1'b0, 1'b1, 19'd11, 16'h0, 16'hA55A, 1'b0);
    run_slot(1'b1, 1'b1, 19'd12, 16'h0F0F, 16'h0, 1'b0);
    idle(1);
    check_idle("R2");
  endtask

  task automatic t_busy_ignore;  // R2: requests while not ready are dropped
    narrow = 1'b0;
    run_slot(1'b0, 1'b1, 19'd12, 16'h0, 16'h0F0F, 1'b1);
    @(negedge clk);
    check_idle("R2");
    chk("R2", "no extra slot addr", mem_addr, 19'd12);
  endtask

  task automatic t_reset_mid;  // R1
    narrow = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_ram = 1'b1;
    req_addr = 19'd14; req_wdata = 16'h7788;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R9", "we pulse before reset", mem_we_n, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after mid reset", req_ready, 1'b1);
    check_idle("R1");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) bmem[i] = 8'(i * 7 + 3);
    t_reset_state();
    t_rom();
    t_ram_wide();
    t_ram_narrow();
    t_back_to_back();
    t_busy_ignore();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule